// File: doc/BRIEF.md
# Converter-Side Serial Result Port

This block is the digital half of a small sampling converter as seen from its three-wire host link. A single start line (`cnvst`) wakes the block, holds it in a track phase while high, and starts a conversion on its falling edge. The pattern of start pulses picks one of two input selections for the sample: the primary selection (first channel, or unipolar coding) or the alternate one (second channel, or bipolar coding). A conversion is timed by an internal cycle counter. When it ends, a result word arriving on `conv_data` is captured together with the selection flag. The word is then shifted out MSB first on `dout`, one bit per falling edge of the host's serial clock.

`dout` has three phases. It is released (output enable low) while idle. It is driven low from the wake-up edge until the result is ready. It then carries data bits until the last one has been clocked out, and is released again. The analog sampling itself lies outside the block, so it serves as a device model for checking a host-side sequencer. All inputs are sampled on `clk`, and edges are found by comparing each input with its value one cycle earlier.

Top module: `sar_serial_port`

## Requirements
- R1: After reset, and in shutdown with no unread result bits, `dout_oe` is 0 and `dout` is 0.
- R2: A rising edge on `cnvst` (low in one cycle, high in the next) causes `dout_oe`=1 and `dout`=0 from the following clock. This holds for the whole track phase and the whole conversion.
- R3: A falling edge on `cnvst` during track starts the conversion and freezes the selection for that sample.
- R4: A rising edge from shutdown with no unread bits selects the primary input (`res_alt`=0). A rising edge that arrives during a conversion abandons that conversion, returns to track and selects the alternate input (`res_alt`=1).
- R5: A rising edge while any result bit is still unread selects the alternate input (`res_alt`=1), and the unread bits are discarded.
- R6: A conversion ends exactly CONV_CYCLES clocks after the clock edge at which its falling edge is detected. At that edge `conv_data` and the selection are captured, the block returns to shutdown, and `dout` shows bit DATA_W-1 with `dout_oe`=1. `res_alt` holds its value until the next conversion ends.
- R7: In the data phase, each falling edge of `sclk` moves `dout` to the next lower bit, MSB first. Without such an edge, `dout` does not change.
- R8: The DATA_W-th falling edge of `sclk` after a result is captured sets `dout_oe` to 0.
- R9: Further `sclk` falling edges in shutdown with no unread bits leave `dout_oe` at 0.
- R10: `sclk` edges during track or conversion are ignored: `dout` stays 0 and no result bit is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnvst | input | 1 | Start / select line from the host |
| sclk | input | 1 | Host serial clock; data advances on its falling edge |
| conv_data | input | DATA_W | Result word captured when a conversion ends |
| dout | output | 1 | Serial data bit; 0 whenever the output is released |
| dout_oe | output | 1 | Output enable of the data pin; 0 means high impedance |
| res_alt | output | 1 | Selection flag captured with the current result (1 = alternate) |

## Verification
Single start pulses, where the primary selection is expected, are set against a double pulse whose second rise lands inside the conversion; this separates the two ways of reaching the alternate selection from the plain case. A readout stopped after five bits, followed by a new pulse, tells the "unread data forces alternate" rule apart from a full readout followed by extra clocks, which must stay released and must not change the next selection. Words with a set MSB, all ones, all zeros and mixed patterns, together with serial clocks toggled during the conversion, show that bits are neither lost nor consumed early. They also show the exact cycle in which the MSB appears.

// File: rtl/sar_sp_pkg.sv
package sar_sp_pkg;
  typedef enum logic [1:0] {
    PH_SHDN  = 2'd0,
    PH_TRACK = 2'd1,
    PH_CONV  = 2'd2
  } phase_t;
endpackage

// File: rtl/sar_sp_edge.sv
module sar_sp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= d;
  end

  assign rise = d & ~prev_q;
  assign fall = ~d & prev_q;
endmodule

// File: rtl/sar_sp_timer.sv
module sar_sp_timer #(
  parameter int CYCLES = 185
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign done   = run && (cnt_q == LAST);
  assign cnt_en = start | (run & ~done);
  assign cnt_d  = start ? '0 : cnt_q + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sar_sp_shifter.sv
module sar_sp_shifter #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] din,
  output logic              bit_o,
  output logic              busy,
  output logic              last
);
  localparam int CW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sr_q;
  logic [CW-1:0]     left_q;

  assign busy  = (left_q != '0);
  assign last  = (left_q == CW'(1));
  assign bit_o = sr_q[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      left_q <= '0;
    end else if (clear) begin
      left_q <= '0;
    end else if (load) begin
      sr_q   <= din;
      left_q <= CW'(DATA_W);
    end else if (shift && busy) begin
      sr_q   <= {sr_q[DATA_W-2:0], 1'b0};
      left_q <= left_q - CW'(1);
    end
  end
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port #(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 185
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnvst,
  input  logic              sclk,
  input  logic [DATA_W-1:0] conv_data,
  output logic              dout,
  output logic              dout_oe,
  output logic              res_alt
);
  import sar_sp_pkg::*;

  logic [1:0] rst_pipe;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  logic c_rise, c_fall, s_rise, s_fall;

  sar_sp_edge u_cedge (.clk(clk), .rst_n(rst_i), .d(cnvst), .rise(c_rise), .fall(c_fall));
  sar_sp_edge u_sedge (.clk(clk), .rst_n(rst_i), .d(sclk),  .rise(s_rise), .fall(s_fall));

  phase_t st, st_nxt;
  logic   sel_alt, sel_nxt;
  logic   hold_alt, hold_nxt;
  logic   res_nxt;
  logic   conv_start, conv_run, conv_done;
  logic   rd_load, rd_clear, rd_shift;
  logic   rd_bit, rd_busy, rd_last;

  assign conv_start = (st == PH_TRACK) & c_fall;
  assign conv_run   = (st == PH_CONV) & ~c_rise;

  sar_sp_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_i), .start(conv_start), .run(conv_run), .done(conv_done)
  );

  sar_sp_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_i), .clear(rd_clear), .load(rd_load), .shift(rd_shift),
    .din(conv_data), .bit_o(rd_bit), .busy(rd_busy), .last(rd_last)
  );

  always_comb begin
    st_nxt   = st;
    sel_nxt  = sel_alt;
    hold_nxt = hold_alt;
    res_nxt  = res_alt;
    rd_load  = 1'b0;
    rd_clear = 1'b0;
    unique case (st)
      PH_SHDN: begin
        if (c_rise) begin
          st_nxt   = PH_TRACK;
          sel_nxt  = rd_busy;
          rd_clear = 1'b1;
        end
      end
      PH_TRACK: begin
        if (c_fall) begin
          st_nxt   = PH_CONV;
          hold_nxt = sel_alt;
        end
      end
      PH_CONV: begin
        if (c_rise) begin
          st_nxt  = PH_TRACK;
          sel_nxt = 1'b1;
        end else if (conv_done) begin
          st_nxt  = PH_SHDN;
          res_nxt = hold_alt;
          rd_load = 1'b1;
        end
      end
      default: st_nxt = PH_SHDN;
    endcase
  end

  assign rd_shift = (st == PH_SHDN) & s_fall & ~c_rise;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st       <= PH_SHDN;
      sel_alt  <= 1'b0;
      hold_alt <= 1'b0;
      res_alt  <= 1'b0;
    end else begin
      st       <= st_nxt;
      sel_alt  <= sel_nxt;
      hold_alt <= hold_nxt;
      res_alt  <= res_nxt;
    end
  end

  assign dout_oe = (st != PH_SHDN) | rd_busy;
  assign dout    = (st == PH_SHDN) & rd_busy & rd_bit;
endmodule

// File: rtl/sar_serial_port_chk.sv
module sar_serial_port_chk (
  input logic                clk,
  input logic                rst_n,
  input logic                cnvst,
  input logic                sclk,
  input logic                dout,
  input logic                dout_oe,
  input sar_sp_pkg::phase_t  st,
  input logic                rd_busy,
  input logic                rd_last,
  input logic                sel_alt
);
  import sar_sp_pkg::*;

  logic pc_q, ps_q;
  logic crise, sfall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= 1'b0;
      ps_q <= 1'b0;
    end else begin
      pc_q <= cnvst;
      ps_q <= sclk;
    end
  end

  assign crise = cnvst & ~pc_q;
  assign sfall = ~sclk & ps_q;

  AST_IDLE_STAYS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_SHDN && !rd_busy && !crise) |=> !dout_oe); // R1
  AST_WAKE_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    crise |=> (dout_oe && !dout)); // R2
  AST_FRESH_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_SHDN && crise && !rd_busy) |=> !sel_alt); // R4
  AST_RETRIGGER_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_CONV && crise) |=> (sel_alt && st == PH_TRACK)); // R4
  AST_UNREAD_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_SHDN && crise && rd_busy) |=> (sel_alt && !rd_busy)); // R5
  AST_HOLD_BETWEEN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_SHDN && rd_busy && !sfall && !crise) |=> $stable(dout)); // R7
  AST_RELEASE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_SHDN && rd_last && sfall && !crise) |=> !dout_oe); // R8
endmodule

bind sar_serial_port sar_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_i), .cnvst(cnvst), .sclk(sclk), .dout(dout),
  .dout_oe(dout_oe), .st(st), .rd_busy(rd_busy), .rd_last(rd_last), .sel_alt(sel_alt)
);

// File: tb/sar_serial_port_test.sv
module sar_serial_port_test;
  localparam int DW = 12;
  localparam int NC = 185;

  logic          clk;
  logic          rst_n;
  logic          cnvst;
  logic          sclk;
  logic [DW-1:0] conv_data;
  logic          dout, dout_oe, res_alt;

  int    checks = 0;
  int    fails  = 0;
  bit    mon_en = 0;
  string cur_req = "R1";

  sar_serial_port #(.DATA_W(DW), .CONV_CYCLES(NC)) uut (
    .clk(clk), .rst_n(rst_n), .cnvst(cnvst), .sclk(sclk), .conv_data(conv_data),
    .dout(dout), .dout_oe(dout_oe), .res_alt(res_alt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural reference: phase 0 shutdown, 1 track, 2 converting
  int            m_ph, m_cnt, m_left;
  bit            m_sel, m_hold, m_res, m_pc, m_ps;
  logic [DW-1:0] m_word;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_left = 0; m_sel = 0; m_hold = 0; m_res = 0;
      m_pc = 0; m_ps = 0; m_word = '0;
    end else begin
      bit cr, cf, sf;
      cr = cnvst && !m_pc;
      cf = !cnvst && m_pc;
      sf = !sclk && m_ps;
      if (m_ph == 0) begin
        if (cr) begin m_sel = (m_left > 0); m_left = 0; m_ph = 1; end
        else if (sf && m_left > 0) begin m_word = m_word << 1; m_left--; end
      end else if (m_ph == 1) begin
        if (cf) begin m_hold = m_sel; m_ph = 2; m_cnt = 0; end
      end else begin
        if (cr) begin m_sel = 1; m_ph = 1; end
        else if (m_cnt == NC - 1) begin
          m_word = conv_data; m_left = DW; m_res = m_hold; m_ph = 0;
        end else m_cnt++;
      end
      m_pc = cnvst;
      m_ps = sclk;
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      logic [2:0] a, e;
      a = {dout_oe, dout, res_alt};
      e = {(m_ph != 0 || m_left > 0), (m_ph == 0 && m_left > 0) ? m_word[DW-1] : 1'b0, m_res};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s (model compare): actual oe/dout/alt=%b expected=%b at %0t", cur_req, a, e, $time);
      end
    end
  end

  task automatic pulse_single();
    @(posedge clk); #3 cnvst = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic pulse_double();
    @(posedge clk); #3 cnvst = 1'b1;
    @(posedge clk); #3 cnvst = 1'b0;
    repeat (3) @(posedge clk);
    #3 cnvst = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic finish_conv();
    @(posedge clk); #3 cnvst = 1'b0;
    repeat (NC + 1) @(posedge clk);
  endtask

  task automatic read_bits(input int n, output logic [DW-1:0] w);
    w = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); w = {w[DW-2:0], dout};
      @(posedge clk); #3 sclk = 1'b1;
      @(posedge clk); #3 sclk = 1'b0;
      @(posedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] w;
    rst_n = 1'b0; cnvst = 1'b0; sclk = 1'b0; conv_data = '0;
    repeat (4) @(posedge clk);
    #3 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    mon_en = 1;
    @(negedge clk);
    chk("R1 idle oe", dout_oe, 0);
    chk("R1 idle dout", dout, 0);

    // single pulse: primary selection, exact conversion length
    cur_req = "R4";
    conv_data = 12'hA5C;
    @(posedge clk); #3 cnvst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R2 track oe", dout_oe, 1);
    chk("R2 track dout", dout, 0);
    repeat (4) @(posedge clk);
    #3 cnvst = 1'b0;
    @(posedge clk);                 // fall detected: conversion starts (R3)
    repeat (NC - 1) @(posedge clk);
    @(negedge clk);
    chk("R3 still converting dout", dout, 0);
    chk("R6 oe before end", dout_oe, 1);
    @(posedge clk);
    @(negedge clk);
    chk("R6 MSB on completion", dout, 1);
    chk("R4 primary after single pulse", res_alt, 0);
    read_bits(DW, w);
    chk("R7 word A5C", w, 12'hA5C);
    @(negedge clk);
    chk("R8 released after last bit", dout_oe, 0);

    // double pulse: second rise during conversion
    cur_req = "R4";
    conv_data = 12'h3C9;
    pulse_double();
    finish_conv();
    @(negedge clk);
    chk("R4 alternate after double pulse", res_alt, 1);
    read_bits(DW, w);
    chk("R7 word 3C9", w, 12'h3C9);

    // partial readout then a new pulse
    cur_req = "R5";
    conv_data = 12'hFFF;
    pulse_single();
    finish_conv();
    @(negedge clk);
    chk("R4 primary after full readout", res_alt, 0);
    read_bits(5, w);
    chk("R7 first five bits of FFF", w, 12'h01F);
    conv_data = 12'h123;
    pulse_single();
    @(negedge clk);
    chk("R5 new track drives low", dout, 0);
    finish_conv();
    @(negedge clk);
    chk("R5 alternate after unread bits", res_alt, 1);
    read_bits(DW, w);
    chk("R5 word 123 after discard", w, 12'h123);

    // extra serial clocks after the last bit
    cur_req = "R9";
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #3 sclk = 1'b1;
      @(posedge clk); #3 sclk = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R9 extra sclk stays released", dout_oe, 0);
    end
    conv_data = 12'h000;
    pulse_single();
    finish_conv();
    @(negedge clk);
    chk("R9 extra clocks keep primary", res_alt, 0);
    read_bits(DW, w);
    chk("R7 word 000", w, 12'h000);

    // serial clock activity during track and conversion
    cur_req = "R10";
    conv_data = 12'h801;
    @(posedge clk); #3 cnvst = 1'b1;
    @(posedge clk); #3 sclk = 1'b1;
    @(posedge clk); #3 sclk = 1'b0;
    @(posedge clk); #3 cnvst = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #3 sclk = 1'b1;
      @(posedge clk); #3 sclk = 1'b0;
      @(negedge clk);
      chk("R10 dout low while converting", dout, 0);
    end
    repeat (NC) @(posedge clk);
    @(negedge clk);
    chk("R10 MSB intact", dout, 1);
    read_bits(DW, w);
    chk("R10 word 801 intact", w, 12'h801);

    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule